// File: doc/BRIEF.md
# Multiplexed MDIO Management Controller

This block is a management-bus master that runs Clause 22 and Clause 45 read and write frames on one of several child MDIO buses. A host programs it through a small 32-bit register file. One register holds the target PHY address, the write data, the Clause 45 flag and the child-bus selection. A second register holds the register (and device) address. A control register starts the transaction, and the host polls a done flag in a status register. Read results come back in a read-data register.

Child buses fall into two groups, internal and external. The selection field gives a group flag and a bus number within the group. Each group has its own rate register. The rate register holds a divisor and a dividend, and the controller derives MDC from the core clock through a fractional accumulator. Only the selected child bus receives clock pulses and drive. All other children stay quiet.

Top module: `mdmx_ctrl`

## Requirements
- R1: After reset every register reads as zero, every child MDC is low and no child MDIO is driven (all output enables low).
- R2: Register map by word index: 0 external rate, 1 internal rate, 2 scan control, 3 parameter, 4 address, 5 control, 6 read data, 7 status. Rate, parameter and address hold and return all 32 bits. Scan control keeps only bit 28 (external-master override) and reads every other bit as zero. Writes to read data and status have no effect.
- R3: Writing 1 (write) or 2 (read) to the control register while idle starts a transaction. Status bit 0 (done) reads low from the next cycle until the last frame bit has been clocked out, then reads high.
- R4: Writing 0 to the control register clears done and abandons any transaction in flight. MDC then stops and MDIO is released.
- R5: A nonzero opcode written while a transaction is in flight is ignored. The control register keeps its value and the running frame continues unchanged.
- R6: A Clause 22 frame is sent MSB first: 32 ones, start 01, opcode 01 (write) or 10 (read), PHY address (parameter bits 20:16), register address (address bits 4:0), turnaround 10 on writes, then 16 data bits (parameter bits 15:0).
- R7: When parameter bit 21 is set, two frames are sent. The first is an address frame (start 00, opcode 00, PHY address, device address from address bits 20:16, turnaround 10, address bits 15:0). The second is a data frame with start 00 and opcode 01 for a write or 11 for a read.
- R8: In a read data frame the controller releases MDIO from bit 46 (turnaround) to the end of the frame. It samples the PHY at each MDC rise of bits 48..63, MSB first. The read-data register then returns those 16 bits, and its upper 16 bits read as zero.
- R9: Parameter bit 25 set selects internal child number bits 24:22. Bit 25 clear selects child NUM_INT plus that number. A number outside its group drives no child, and the transaction still completes.
- R10: At most one child has MDC high or MDIO driven at any time, and only the selected child ever does.
- R11: MDC timing comes from the selected group's rate register: divisor in bits 15:0, dividend in bits 31:16, zero treated as one. When the dividend divides the divisor, each MDC half period lasts divisor/dividend core cycles. MDIO changes only while MDC is low, and MDC stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register word index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| mdc_o | output | NUM_INT+NUM_EXT | Per-child management clock |
| mdio_out | output | NUM_INT+NUM_EXT | Per-child MDIO output value |
| mdio_oe | output | NUM_INT+NUM_EXT | Per-child MDIO output enable |
| mdio_in | input | NUM_INT+NUM_EXT | Per-child MDIO input |

## Verification
The assertions check four properties on every cycle. At most one child is clocked or driven. MDIO and its enable hold steady while MDC is high. MDC is low while the engine is idle. A read frame keeps its output enable low from the turnaround onward. They also check that done rises only as the engine goes idle, and that a busy-time opcode leaves the control register untouched. The bench scenarios cover the rest: the exact bit order of Clause 22 and Clause 45 frames, the mapping of group and number to a child, the choice of rate register and the resulting MDC period, the assembly of read data, and the effect of an abort.

// File: rtl/mdmx_pkg.sv
package mdmx_pkg;
    localparam int WORD_W       = 32;
    localparam int RATE_W       = 16;
    localparam int DATA_W       = 16;
    localparam int PHY_W        = 5;
    localparam int BUS_ID_W     = 3;
    localparam int INT_SEL_BIT  = 25;
    localparam int BUS_ID_LSB   = 22;
    localparam int C45_SEL_BIT  = 21;
    localparam int PHY_LSB      = 16;
    localparam int SCAN_OVR_BIT = 28;
    localparam int PARAM_KEEP   = INT_SEL_BIT + 1;
    localparam int ADDR_KEEP    = DATA_W + PHY_W;
    localparam int FRAME_W      = 64;
    localparam int TA_IDX       = 46;
    localparam int DATA_IDX     = 48;
    localparam int CNT_W        = $clog2(FRAME_W);

    typedef enum logic [2:0] {
        RI_RATE_EXT = 3'd0,
        RI_RATE_INT = 3'd1,
        RI_SCAN     = 3'd2,
        RI_PARAM    = 3'd3,
        RI_ADDR     = 3'd4,
        RI_CTRL     = 3'd5,
        RI_RDATA    = 3'd6,
        RI_STATUS   = 3'd7
    } reg_idx_e;

    localparam logic [1:0] OP_IDLE  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;

    typedef struct packed {
        logic [1:0]        st;
        logic [1:0]        op;
        logic [PHY_W-1:0]  fa;
        logic [PHY_W-1:0]  fb;
        logic              rd;
        logic [DATA_W-1:0] data;
    } frame_hdr_t;

    function automatic logic [FRAME_W-1:0] pack_frame(frame_hdr_t h);
        return {32'hFFFF_FFFF, h.st, h.op, h.fa, h.fb,
                h.rd ? 2'b00 : 2'b10, h.rd ? {DATA_W{1'b0}} : h.data};
    endfunction
endpackage

// File: rtl/mdmx_regs.sv
module mdmx_regs
    import mdmx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [2:0]           addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    input  logic                 busy,
    input  logic                 xact_done,
    input  logic [DATA_W-1:0]    rd_result,
    output logic                 start,
    output logic                 start_rd,
    output logic                 abort,
    output logic [PARAM_KEEP-1:0] param,
    output logic [ADDR_KEEP-1:0]  xaddr,
    output logic [WORD_W-1:0]    rate_ext,
    output logic [WORD_W-1:0]    rate_int
);
    logic [WORD_W-1:0] param_q, addr_q, rext_q, rint_q;
    logic              scan_ovr_q, done_q;
    logic [1:0]        op_q;
    logic [DATA_W-1:0] rdq;
    logic              ctrl_wr, op_ok;

    assign ctrl_wr  = we && (reg_idx_e'(addr) == RI_CTRL);
    assign op_ok    = (wdata[1:0] == OP_WRITE) || (wdata[1:0] == OP_READ);
    assign start    = ctrl_wr && !busy && op_ok;
    assign abort    = ctrl_wr && (wdata[1:0] == OP_IDLE);
    assign start_rd = (wdata[1:0] == OP_READ);
    assign param    = param_q[PARAM_KEEP-1:0];
    assign xaddr    = addr_q[ADDR_KEEP-1:0];
    assign rate_ext = rext_q;
    assign rate_int = rint_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            param_q <= '0; addr_q <= '0; rext_q <= '0; rint_q <= '0;
            scan_ovr_q <= 1'b0; done_q <= 1'b0; op_q <= OP_IDLE; rdq <= '0;
        end else begin
            if (xact_done) begin
                done_q <= 1'b1;
                if (op_q == OP_READ) rdq <= rd_result;
            end
            if (we) begin
                case (reg_idx_e'(addr))
                    RI_RATE_EXT: rext_q  <= wdata;
                    RI_RATE_INT: rint_q  <= wdata;
                    RI_SCAN:     scan_ovr_q <= wdata[SCAN_OVR_BIT];
                    RI_PARAM:    param_q <= wdata;
                    RI_ADDR:     addr_q  <= wdata;
                    RI_CTRL: begin
                        if (abort) begin
                            op_q <= OP_IDLE; done_q <= 1'b0;
                        end else if (start) begin
                            op_q <= wdata[1:0]; done_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_idx_e'(addr))
            RI_RATE_EXT: rdata = rext_q;
            RI_RATE_INT: rdata = rint_q;
            RI_SCAN:     rdata = {{(WORD_W-SCAN_OVR_BIT-1){1'b0}}, scan_ovr_q, {SCAN_OVR_BIT{1'b0}}};
            RI_PARAM:    rdata = param_q;
            RI_ADDR:     rdata = addr_q;
            RI_CTRL:     rdata = {{(WORD_W-2){1'b0}}, op_q};
            RI_RDATA:    rdata = {{(WORD_W-DATA_W){1'b0}}, rdq};
            default:     rdata = {{(WORD_W-1){1'b0}}, done_q};
        endcase
    end

    // R5
    busy_op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr && wdata[1:0] != OP_IDLE) |=> $stable(op_q));
    // R3
    done_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $fell(busy));
endmodule

// File: rtl/mdmx_mdc_gen.sv
module mdmx_mdc_gen
    import mdmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] dividend,
    input  logic [RATE_W-1:0] divisor,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    logic [RATE_W-1:0] acc_q, dvd_e, dvs_e;
    logic [RATE_W:0]   sum;
    logic              mdc_q, step, big;

    assign dvd_e = (dividend == '0) ? RATE_W'(1) : dividend;
    assign dvs_e = (divisor  == '0) ? RATE_W'(1) : divisor;
    assign sum   = {1'b0, acc_q} + {1'b0, dvd_e};
    assign step  = sum >= {1'b0, dvs_e};
    assign big   = dvd_e >= dvs_e;
    assign rise  = run && step && !mdc_q;
    assign fall  = run && step && mdc_q;
    assign mdc   = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q <= '0;
            mdc_q <= 1'b0;
        end else if (step) begin
            acc_q <= big ? '0 : RATE_W'(sum - {1'b0, dvs_e});
            mdc_q <= ~mdc_q;
        end else begin
            acc_q <= sum[RATE_W-1:0];
        end
    end

    // R11
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst) !run |=> !mdc_q);
    // R11
    mdc_rise_chk: assert property (@(posedge clk) disable iff (rst) rise |=> mdc_q);
endmodule

// File: rtl/mdmx_frame.sv
module mdmx_frame
    import mdmx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_rd,
    input  logic               abort,
    input  logic               c45,
    input  logic [PHY_W-1:0]   phy,
    input  logic [ADDR_KEEP-1:0] xaddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rise,
    input  logic               fall,
    input  logic               mdio_in,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               xact_done,
    output logic [DATA_W-1:0]  rd_result
);
    logic [FRAME_W-1:0] sh_q, nxt_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  rdsh_q;
    logic               busy_q, pend_q, rd_q, nrd_q, oe_q, last_bit;
    frame_hdr_t         hdr_c22, hdr_adr, hdr_c45;
    logic [PHY_W-1:0]   dev;

    assign dev = xaddr[ADDR_KEEP-1:DATA_W];
    always_comb begin
        hdr_c22 = '{st: 2'b01, op: start_rd ? 2'b10 : 2'b01, fa: phy,
                    fb: xaddr[PHY_W-1:0], rd: start_rd, data: wdata};
        hdr_adr = '{st: 2'b00, op: 2'b00, fa: phy, fb: dev, rd: 1'b0,
                    data: xaddr[DATA_W-1:0]};
        hdr_c45 = '{st: 2'b00, op: start_rd ? 2'b11 : 2'b01, fa: phy, fb: dev,
                    rd: start_rd, data: wdata};
    end

    assign last_bit  = (cnt_q == CNT_W'(FRAME_W-1));
    assign busy      = busy_q;
    assign mdio_o    = sh_q[FRAME_W-1];
    assign mdio_oe   = oe_q;
    assign rd_result = rdsh_q;
    assign xact_done = busy_q && !abort && fall && last_bit && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0; pend_q <= 1'b0; rd_q <= 1'b0; nrd_q <= 1'b0;
            oe_q <= 1'b0; cnt_q <= '0; sh_q <= '0; nxt_q <= '0; rdsh_q <= '0;
        end else if (abort) begin
            busy_q <= 1'b0; pend_q <= 1'b0; oe_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1; oe_q <= 1'b1; cnt_q <= '0;
            sh_q   <= c45 ? pack_frame(hdr_adr) : pack_frame(hdr_c22);
            rd_q   <= c45 ? 1'b0 : start_rd;
            nxt_q  <= pack_frame(hdr_c45);
            nrd_q  <= start_rd;
            pend_q <= c45;
        end else if (busy_q) begin
            if (rise && rd_q && cnt_q >= CNT_W'(DATA_IDX))
                rdsh_q <= {rdsh_q[DATA_W-2:0], mdio_in};
            if (fall) begin
                if (last_bit) begin
                    cnt_q <= '0;
                    if (pend_q) begin
                        sh_q <= nxt_q; rd_q <= nrd_q; pend_q <= 1'b0; oe_q <= 1'b1;
                    end else begin
                        busy_q <= 1'b0; oe_q <= 1'b0;
                    end
                end else begin
                    sh_q  <= sh_q << 1;
                    cnt_q <= cnt_q + CNT_W'(1);
                    oe_q  <= !(rd_q && (cnt_q + CNT_W'(1) >= CNT_W'(TA_IDX)));
                end
            end
        end
    end

    // R8
    ta_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && rd_q && cnt_q >= CNT_W'(TA_IDX)) |-> !oe_q);
endmodule

// File: rtl/mdmx_ctrl.sv
module mdmx_ctrl
    import mdmx_pkg::*;
#(
    parameter int NUM_INT = 4,
    parameter int NUM_EXT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_we,
    input  logic [2:0]                 host_addr,
    input  logic [31:0]                host_wdata,
    output logic [31:0]                host_rdata,
    output logic [NUM_INT+NUM_EXT-1:0] mdc_o,
    output logic [NUM_INT+NUM_EXT-1:0] mdio_out,
    output logic [NUM_INT+NUM_EXT-1:0] mdio_oe,
    input  logic [NUM_INT+NUM_EXT-1:0] mdio_in
);
    localparam int NCH   = NUM_INT + NUM_EXT;
    localparam int SEL_W = BUS_ID_W + 1;

    logic [PARAM_KEEP-1:0] param;
    logic [ADDR_KEEP-1:0]  xaddr;
    logic [WORD_W-1:0]     rate_ext, rate_int;
    logic [DATA_W-1:0]     rd_res;
    logic start, start_rd, abort, busy, xdone, mdc, rise, fall, mdio_d, oe, sel_in;
    logic [BUS_ID_W-1:0] p_id;
    logic [SEL_W-1:0]    p_idx, sel_q;
    logic p_int, p_vld, sel_vld_q, sel_int_q;
    logic [RATE_W-1:0]   dvd, dvs;

    mdmx_regs u_regs (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .rdata(host_rdata), .busy(busy), .xact_done(xdone), .rd_result(rd_res),
        .start(start), .start_rd(start_rd), .abort(abort), .param(param),
        .xaddr(xaddr), .rate_ext(rate_ext), .rate_int(rate_int)
    );

    // group/number decode, frozen for the whole transaction
    assign p_int = param[INT_SEL_BIT];
    assign p_id  = param[BUS_ID_LSB +: BUS_ID_W];
    assign p_vld = p_int ? (int'(p_id) < NUM_INT) : (int'(p_id) < NUM_EXT);
    assign p_idx = p_int ? {1'b0, p_id} : {1'b0, p_id} + SEL_W'(NUM_INT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0; sel_vld_q <= 1'b0; sel_int_q <= 1'b0;
        end else if (start) begin
            sel_q <= p_idx; sel_vld_q <= p_vld; sel_int_q <= p_int;
        end
    end

    assign dvs = sel_int_q ? rate_int[RATE_W-1:0] : rate_ext[RATE_W-1:0];
    assign dvd = sel_int_q ? rate_int[WORD_W-1:RATE_W] : rate_ext[WORD_W-1:RATE_W];

    mdmx_mdc_gen u_mdc (
        .clk(clk), .rst(rst), .run(busy), .dividend(dvd), .divisor(dvs),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdmx_frame u_frame (
        .clk(clk), .rst(rst), .start(start), .start_rd(start_rd), .abort(abort),
        .c45(param[C45_SEL_BIT]), .phy(param[PHY_LSB +: PHY_W]), .xaddr(xaddr),
        .wdata(param[DATA_W-1:0]), .rise(rise), .fall(fall), .mdio_in(sel_in),
        .busy(busy), .mdio_o(mdio_d), .mdio_oe(oe), .xact_done(xdone), .rd_result(rd_res)
    );

    always_comb begin
        sel_in = 1'b1;
        for (int k = 0; k < NCH; k++)
            if (sel_vld_q && sel_q == SEL_W'(k)) sel_in = mdio_in[k];
    end

    for (genvar k = 0; k < NCH; k++) begin : g_child
        logic hit;
        assign hit         = sel_vld_q && (sel_q == SEL_W'(k));
        assign mdc_o[k]    = hit && mdc;
        assign mdio_out[k] = hit && mdio_d;
        assign mdio_oe[k]  = hit && oe;
    end

    // R10
    one_clocked_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(mdc_o));
    // R10
    one_driven_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(mdio_oe));
    // R11
    mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mdc |-> ($stable(mdio_d) && $stable(oe)));
endmodule

// File: tb/test_mdmx_ctrl.sv
`timescale 1ns/1ps
module test_mdmx_ctrl;
    localparam int NI = 4;
    localparam int NE = 4;
    localparam int N  = NI + NE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic [N-1:0] mdc_o, mdio_out, mdio_oe, mdio_in;

    always #2.5 clk = ~clk;

    mdmx_ctrl #(.NUM_INT(NI), .NUM_EXT(NE)) i_mdmx_ctrl (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc_o(mdc_o),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int checks = 0, fails = 0;
    int rises = 0, stray = 0, hold_err = 0, cyc = 0, last_rise = 0, base = 0, exp_sel = -1;
    logic cap_bit [1024];
    logic cap_oe  [1024];
    int   per     [1024];
    logic [15:0] rd_pat = 16'h5A3C;
    logic rd_bit;
    logic [N-1:0] mdc_prev = '0, out_prev = '0;

    // PHY side: drive read data bit for the next sampling rise
    always_comb begin
        rd_bit = 1'b1;
        if (((rises - base) & 63) >= 48) rd_bit = rd_pat[63 - ((rises - base) & 63)];
    end
    assign mdio_in = {N{rd_bit}};

    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < N; k++) begin
            if (k == exp_sel) begin
                if (mdc_o[k] && !mdc_prev[k]) begin
                    cap_bit[rises & 1023] = mdio_out[k];
                    cap_oe[rises & 1023]  = mdio_oe[k];
                    per[rises & 1023]     = cyc - last_rise;
                    last_rise = cyc;
                    rises++;
                end
                if (mdc_prev[k] && mdc_o[k] && mdio_out[k] != out_prev[k]) hold_err++;
            end else if (mdc_o[k] || mdio_oe[k]) begin
                stray++;
            end
        end
        mdc_prev = mdc_o;
        out_prev = mdio_out;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        bit got = 1'b0;
        for (int i = 0; i < 3000 && !got; i++) begin
            rd(3'd7, s);
            got = s[0];
        end
        chk(got, req, {31'd0, got}, 32'd1);
    endtask

    function automatic logic [31:0] mkparam(input bit intl, input int id, input bit c45,
                                            input int phy, input logic [15:0] d);
        return (32'(intl) << 25) | (32'(id) << 22) | (32'(c45) << 21) | (32'(phy) << 16) | {16'd0, d};
    endfunction

    function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [15:0] d);
        return {32'hFFFF_FFFF, st, op, a, b, 2'b10, d};
    endfunction

    task automatic check_bits(input logic [63:0] exp, input int at, input int nbits, input string req);
        int bad = 0;
        for (int i = 0; i < nbits; i++)
            if (cap_bit[(at + i) & 1023] !== exp[63 - i]) bad++;
        chk(bad == 0, req, 32'(bad), 32'd0);
    endtask

    task automatic check_oe(input int at, input int rel_from, input string req);
        int bad = 0;
        for (int i = 0; i < 64; i++)
            if (cap_oe[(at + i) & 1023] !== (i < rel_from)) bad++;
        chk(bad == 0, req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset_and_map;
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 32'd0, "R1 register zero after reset", v, 32'd0);
        end
        chk(mdc_o == '0 && mdio_oe == '0, "R1 children quiet", {mdc_o, mdio_oe}, 32'd0);
        wr(3'd4, 32'h1234_5678); rd(3'd4, v);
        chk(v == 32'h1234_5678, "R2 address readback", v, 32'h1234_5678);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v);
        chk(v == 32'h1000_0000, "R2 scan override bit only", v, 32'h1000_0000);
        wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, v);
        chk(v == 32'd0, "R2 status write ignored", v, 32'd0);
        wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v);
        chk(v == 32'd0, "R2 read data write ignored", v, 32'd0);
    endtask

    task automatic t_c22_write;
        logic [31:0] v;
        int s0;
        exp_sel = 2;
        wr(3'd1, {16'd1, 16'd3});
        wr(3'd3, mkparam(1'b1, 2, 1'b0, 5, 16'hA5C3));
        wr(3'd4, 32'h0000_000B);
        base = rises; s0 = stray;
        wr(3'd5, 32'd1);
        rd(3'd7, v);
        chk(v[0] == 1'b0, "R3 done low while running", v, 32'd0);
        wait_done("R3 write completes");
        chk(rises - base == 64, "R6 write bit count", 32'(rises - base), 32'd64);
        check_bits(fr(2'b01, 2'b01, 5'd5, 5'd11, 16'hA5C3), base, 64, "R6 clause 22 write frame");
        check_oe(base, 64, "R6 write keeps MDIO driven");
        chk(per[(base + 10) & 1023] == 6, "R11 internal rate period", 32'(per[(base + 10) & 1023]), 32'd6);
        chk(stray == s0, "R10 no activity on other children", 32'(stray - s0), 32'd0);
        chk(hold_err == 0, "R11 MDIO stable while MDC high", 32'(hold_err), 32'd0);
        wr(3'd5, 32'd0); rd(3'd7, v);
        chk(v == 32'd0, "R4 zero opcode clears done", v, 32'd0);
    endtask

    task automatic t_c22_read;
        logic [31:0] v;
        int s0;
        exp_sel = NI + 1;
        rd_pat = 16'h5A3C;
        wr(3'd0, {16'd1, 16'd2});
        wr(3'd3, mkparam(1'b0, 1, 1'b0, 3, 16'h0));
        wr(3'd4, 32'h0000_0011);
        base = rises; s0 = stray;
        wr(3'd5, 32'd2);
        wait_done("R3 read completes");
        chk(rises - base == 64, "R9 external child 5 clocked", 32'(rises - base), 32'd64);
        check_bits(fr(2'b01, 2'b10, 5'd3, 5'h11, 16'h0), base, 46, "R6 clause 22 read header");
        check_oe(base, 46, "R8 read releases MDIO from turnaround");
        rd(3'd6, v);
        chk(v == 32'h0000_5A3C, "R8 read data", v, 32'h0000_5A3C);
        chk(per[(base + 10) & 1023] == 4, "R11 external rate period", 32'(per[(base + 10) & 1023]), 32'd4);
        chk(stray == s0, "R9 only external child selected", 32'(stray - s0), 32'd0);
    endtask

    task automatic t_c45_read;
        logic [31:0] v;
        exp_sel = 0;
        rd_pat = 16'hC3E1;
        wr(3'd1, {16'd2, 16'd6});
        wr(3'd3, mkparam(1'b1, 0, 1'b1, 7, 16'h0));
        wr(3'd4, {11'd0, 5'd3, 16'h1234});
        wr(3'd5, 32'd0);
        base = rises;
        wr(3'd5, 32'd2);
        wait_done("R3 clause 45 read completes");
        chk(rises - base == 128, "R7 two frames", 32'(rises - base), 32'd128);
        check_bits(fr(2'b00, 2'b00, 5'd7, 5'd3, 16'h1234), base, 64, "R7 address frame");
        check_bits(fr(2'b00, 2'b11, 5'd7, 5'd3, 16'h0), base + 64, 46, "R7 read data frame header");
        check_oe(base, 64, "R7 address frame driven");
        check_oe(base + 64, 46, "R8 clause 45 read release");
        rd(3'd6, v);
        chk(v == 32'h0000_C3E1, "R8 clause 45 read data", v, 32'h0000_C3E1);
        chk(per[(base + 20) & 1023] == 6, "R11 dividend 2 divisor 6", 32'(per[(base + 20) & 1023]), 32'd6);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        exp_sel = 2;
        wr(3'd1, {16'd1, 16'd3});
        wr(3'd3, mkparam(1'b1, 2, 1'b0, 9, 16'h0F0F));
        wr(3'd4, 32'h0000_000B);
        wr(3'd5, 32'd0);
        base = rises;
        wr(3'd5, 32'd1);
        repeat (60) @(negedge clk);
        wr(3'd5, 32'd2);
        rd(3'd5, v);
        chk(v == 32'd1, "R5 busy opcode ignored", v, 32'd1);
        rd(3'd7, v);
        chk(v[0] == 1'b0, "R5 done still low", v, 32'd0);
        wait_done("R5 original write completes");
        check_bits(fr(2'b01, 2'b01, 5'd9, 5'd11, 16'h0F0F), base, 64, "R5 frame unchanged");
        check_oe(base, 64, "R5 still a write");
    endtask

    task automatic t_abort;
        logic [31:0] v;
        int r0;
        wr(3'd5, 32'd0);
        wr(3'd5, 32'd1);
        repeat (100) @(negedge clk);
        wr(3'd5, 32'd0);
        rd(3'd7, v);
        chk(v == 32'd0, "R4 abort leaves done low", v, 32'd0);
        repeat (3) @(negedge clk);
        r0 = rises;
        repeat (80) @(negedge clk);
        chk(rises == r0, "R4 MDC stops after abort", 32'(rises - r0), 32'd0);
        chk(mdc_o == '0 && mdio_oe == '0, "R4 bus released", {mdc_o, mdio_oe}, 32'd0);
    endtask

    task automatic t_bad_bus;
        int s0;
        exp_sel = -1;
        wr(3'd3, mkparam(1'b1, 6, 1'b0, 1, 16'h0));
        wr(3'd5, 32'd0);
        s0 = stray;
        wr(3'd5, 32'd1);
        wait_done("R9 out-of-range bus still completes");
        chk(stray == s0, "R9 out-of-range bus drives nothing", 32'(stray - s0), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_and_map();
        t_c22_write();
        t_c22_read();
        t_c45_read();
        t_busy_ignore();
        t_abort();
        t_bad_bus();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule